// File: doc/BRIEF.md
# Cache Tag Store with Compare

This block holds one tag per line of a direct-mapped cache, together with three status flags per line: valid, dirty and write-through. It is addressed by the cache index. A host uses it in one of four ways in a given cycle. It can read back the tag and the flags of an entry, write a new tag, write the flags, or present an incoming tag for comparison against the stored one. Every request is sampled on the rising clock edge. Its result appears on the registered outputs during the following cycle.

The comparison drives a hit flag and an active-low acknowledge. A mode input selects how the flags act. In qualified mode a line that is not valid never hits, and a line that is not valid or is marked write-through never acknowledges. In plain mode the flags are simple storage and the hit depends only on the tag equality. The acknowledge also merges an acknowledge from an external agent, which is sampled on the same edge. A hold input lets a qualified hit acknowledge on its own, and a force input suppresses the acknowledge. Each bus that would be bidirectional on a pad is split into an input, an output and an output enable.

The control path is a four-state cycle machine. The states are `ST_IDLE` (deselected), `ST_READ`, `ST_WRITE` and `ST_CMP`. On each edge the decoded request picks the next state, and any state may move to any other. `ST_IDLE` is taken when the chip selects are inactive. `ST_WRITE` is taken when either write enable is low. `ST_READ` is taken when the read enable is low and neither write enable is low. `ST_CMP` is taken when all three enables are high. Reset forces `ST_IDLE`.

Top module: `tag_cache_store`

## Requirements
- R1: When `sel1_n` is high or `sel2` is low at an edge, the next cycle has `hit_oe`=0, `tag_rd_oe`=0 and `ack_n`=1.
- R2: A selected edge with `rd_en_n`=0 and both write enables high gives, in the next cycle, `tag_rd_oe`=1, `hit`=0, `tag_rd` equal to the stored tag, and `flags_rd` equal to the stored flags. In `flags_rd`, bit 0 is valid, bit 1 is dirty and bit 2 is write-through.
- R3: A selected edge with `tag_wr_n`=0 stores `tag_in` at `index`. The next cycle shows `tag_rd_oe`=0 and `hit`=0.
- R4: A selected edge with `flags_wr_n`=0 stores `{flag_wt_in, flag_dirty_in, flag_valid_in}` at `index`. It acts independently of a tag write in the same cycle.
- R5: A selected edge with all three enables high is a compare. In the next cycle `hit_oe`=1, and `hit` is 1 only if `tag_in` equals the stored tag, qualified as R6 and R7 state.
- R6: With `plain_mode`=0, a stored valid flag of 0 forces `hit` to 0.
- R7: With `plain_mode`=1, `hit` is the tag equality alone, whatever the stored flags hold.
- R8: A compare with `ack_force_hi`=1 gives `ack_n`=1.
- R9: With `plain_mode`=0, a compare on an entry whose valid flag is 0 or whose write-through flag is 1 gives `ack_n`=1.
- R10: A compare with `ack_hold`=1 and a qualified hit, not blocked by R8 or R9, gives `ack_n`=0 whatever `ext_ack_n` is.
- R11: In any other compare, `ack_n` is 0 only when the hit is qualified and `ext_ack_n` was 0 at the edge. Every cycle that follows a non-compare edge has `ack_n`=1.
- R12: `ack_oe` is the inverse of `ack_oe_n` and does not wait for the clock.
- R13: A synchronous low `rst_n` clears every valid flag. The next cycle has `hit_oe`=0, `tag_rd_oe`=0 and `ack_n`=1.
- R14: A compare issued in the cycle right after a tag or flag write to the same index sees the newly written contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| sel1_n | input | 1 | Chip select, active low |
| sel2 | input | 1 | Chip select, active high |
| plain_mode | input | 1 | 1 = flags are plain storage, 0 = flags qualify hit and acknowledge |
| index | input | IDX_W | Entry address |
| rd_en_n | input | 1 | Read request, active low |
| tag_wr_n | input | 1 | Tag write, active low |
| flags_wr_n | input | 1 | Flag write, active low |
| tag_in | input | TAG_W | Write data and compare tag |
| flag_valid_in | input | 1 | Valid flag to write |
| flag_dirty_in | input | 1 | Dirty flag to write |
| flag_wt_in | input | 1 | Write-through flag to write |
| tag_rd | output | TAG_W | Tag read data |
| flags_rd | output | 3 | Read flags: bit 0 valid, bit 1 dirty, bit 2 write-through |
| tag_rd_oe | output | 1 | Enable for tag_rd and flags_rd |
| hit | output | 1 | Compare result |
| hit_oe | output | 1 | Enable for hit |
| ack_force_hi | input | 1 | Forces the acknowledge inactive |
| ack_hold | input | 1 | Lets a qualified hit acknowledge on its own |
| ext_ack_n | input | 1 | External acknowledge, active low, sampled on the edge |
| ack_oe_n | input | 1 | Acknowledge output enable, active low |
| ack_n | output | 1 | Acknowledge, active low |
| ack_oe | output | 1 | Enable for ack_n |

## Verification
A lost or wrong valid flag shows on the compare one cycle after it is issued: a written line misses, or a cleared line hits or acknowledges. It also shows on a read one cycle later through bit 0 of `flags_rd`. A stuck cycle state shows immediately in the next cycle, as a wrong `hit_oe` or `tag_rd_oe` level, or as an acknowledge in a non-compare cycle. A stale array read shows in the compare that directly follows a write, because the bench places that compare back to back with the write.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_CMP   = 2'd3
    } cyc_e;

    typedef struct packed {
        logic wt;
        logic dirty;
        logic valid;
    } flags_t;

endpackage

// File: rtl/tcs_decode.sv
module tcs_decode
    import tcs_pkg::*;
(
    input  logic sel1_n,
    input  logic sel2,
    input  logic rd_en_n,
    input  logic tag_wr_n,
    input  logic flags_wr_n,
    output cyc_e next_cyc,
    output logic do_tag_wr,
    output logic do_flags_wr
);

    logic selected;

    always_comb begin
        selected    = !sel1_n && sel2;
        do_tag_wr   = selected && !tag_wr_n;
        do_flags_wr = selected && !flags_wr_n;
        if (!selected)
            next_cyc = ST_IDLE;
        else if (do_tag_wr || do_flags_wr)
            next_cyc = ST_WRITE;
        else if (!rd_en_n)
            next_cyc = ST_READ;
        else
            next_cyc = ST_CMP;
    end

endmodule

// File: rtl/tcs_array.sv
module tcs_array
    import tcs_pkg::*;
#(
    parameter int IDX_W = 10,
    parameter int TAG_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_tag,
    input  logic             wr_flags,
    input  logic [IDX_W-1:0] index,
    input  logic [TAG_W-1:0] tag_wdata,
    input  flags_t           flags_wdata,
    output logic [TAG_W-1:0] tag_rdata,
    output flags_t           flags_rdata
);

    localparam int DEPTH = 1 << IDX_W;

    logic [TAG_W-1:0] tag_mem [DEPTH];
    logic [DEPTH-1:0] valid_q;
    logic [DEPTH-1:0] dirty_q;
    logic [DEPTH-1:0] wt_q;

    // Tag storage: never reset, written only outside reset.
    always_ff @(posedge clk) begin
        if (rst_n && wr_tag)
            tag_mem[index] <= tag_wdata;
    end

    // Valid flags live in flops so that reset clears them in one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            valid_q <= '0;
        else if (wr_flags)
            valid_q[index] <= flags_wdata.valid;
    end

    always_ff @(posedge clk) begin
        if (rst_n && wr_flags) begin
            dirty_q[index] <= flags_wdata.dirty;
            wt_q[index]    <= flags_wdata.wt;
        end
    end

    always_comb begin
        tag_rdata         = tag_mem[index];
        flags_rdata.valid = valid_q[index];
        flags_rdata.dirty = dirty_q[index];
        flags_rdata.wt    = wt_q[index];
    end

endmodule

// File: rtl/tcs_resolve.sv
module tcs_resolve
    import tcs_pkg::*;
#(
    parameter int TAG_W = 12
) (
    input  logic             is_cmp,
    input  logic             plain_mode,
    input  logic [TAG_W-1:0] tag_in,
    input  logic [TAG_W-1:0] tag_stored,
    input  flags_t           flags_stored,
    input  logic             ack_force_hi,
    input  logic             ack_hold,
    input  logic             ext_ack_n,
    output logic             hit_next,
    output logic             ack_next_n
);

    logic tag_eq;
    logic qual_hit;
    logic blocked;

    always_comb begin
        tag_eq   = (tag_in == tag_stored);
        qual_hit = plain_mode ? tag_eq : (tag_eq && flags_stored.valid);
        blocked  = ack_force_hi ||
                   (!plain_mode && (!flags_stored.valid || flags_stored.wt));
        hit_next = is_cmp && qual_hit;
        if (!is_cmp || blocked)
            ack_next_n = 1'b1;
        else if (qual_hit && ack_hold)
            ack_next_n = 1'b0;
        else
            ack_next_n = !qual_hit || ext_ack_n;
    end

endmodule

// File: rtl/tag_cache_store.sv
module tag_cache_store
    import tcs_pkg::*;
#(
    parameter int IDX_W = 10,
    parameter int TAG_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel1_n,
    input  logic             sel2,
    input  logic             plain_mode,
    input  logic [IDX_W-1:0] index,
    input  logic             rd_en_n,
    input  logic             tag_wr_n,
    input  logic             flags_wr_n,
    input  logic [TAG_W-1:0] tag_in,
    input  logic             flag_valid_in,
    input  logic             flag_dirty_in,
    input  logic             flag_wt_in,
    output logic [TAG_W-1:0] tag_rd,
    output logic [2:0]       flags_rd,
    output logic             tag_rd_oe,
    output logic             hit,
    output logic             hit_oe,
    input  logic             ack_force_hi,
    input  logic             ack_hold,
    input  logic             ext_ack_n,
    input  logic             ack_oe_n,
    output logic             ack_n,
    output logic             ack_oe
);

    cyc_e             cyc_q;
    cyc_e             next_cyc;
    logic             do_tag_wr;
    logic             do_flags_wr;
    logic [TAG_W-1:0] arr_tag;
    flags_t           arr_flags;
    flags_t           wr_flags;
    logic             hit_next;
    logic             ack_next_n;
    logic             hit_q;
    logic             ack_q_n;
    logic [TAG_W-1:0] tag_q;
    flags_t           flags_q;

    assign wr_flags = '{wt: flag_wt_in, dirty: flag_dirty_in, valid: flag_valid_in};

    tcs_decode u_decode (
        .sel1_n      (sel1_n),
        .sel2        (sel2),
        .rd_en_n     (rd_en_n),
        .tag_wr_n    (tag_wr_n),
        .flags_wr_n  (flags_wr_n),
        .next_cyc    (next_cyc),
        .do_tag_wr   (do_tag_wr),
        .do_flags_wr (do_flags_wr)
    );

    tcs_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_array (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_tag      (do_tag_wr),
        .wr_flags    (do_flags_wr),
        .index       (index),
        .tag_wdata   (tag_in),
        .flags_wdata (wr_flags),
        .tag_rdata   (arr_tag),
        .flags_rdata (arr_flags)
    );

    tcs_resolve #(.TAG_W(TAG_W)) u_resolve (
        .is_cmp       (next_cyc == ST_CMP),
        .plain_mode   (plain_mode),
        .tag_in       (tag_in),
        .tag_stored   (arr_tag),
        .flags_stored (arr_flags),
        .ack_force_hi (ack_force_hi),
        .ack_hold     (ack_hold),
        .ext_ack_n    (ext_ack_n),
        .hit_next     (hit_next),
        .ack_next_n   (ack_next_n)
    );

    // State register and captured results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q   <= ST_IDLE;
            hit_q   <= 1'b0;
            ack_q_n <= 1'b1;
            tag_q   <= '0;
            flags_q <= '0;
        end else begin
            cyc_q   <= next_cyc;
            hit_q   <= hit_next;
            ack_q_n <= ack_next_n;
            if (next_cyc == ST_READ) begin
                tag_q   <= arr_tag;
                flags_q <= arr_flags;
            end
        end
    end

    // Outputs per state
    always_comb begin
        tag_rd    = tag_q;
        flags_rd  = flags_q;
        ack_oe    = !ack_oe_n;
        tag_rd_oe = 1'b0;
        hit_oe    = 1'b0;
        hit       = 1'b0;
        ack_n     = 1'b1;
        unique case (cyc_q)
            ST_IDLE:  ;
            ST_READ: begin
                tag_rd_oe = 1'b1;
                hit_oe    = 1'b1;
            end
            ST_WRITE: hit_oe = 1'b1;
            ST_CMP: begin
                hit_oe = 1'b1;
                hit    = hit_q;
                ack_n  = ack_q_n;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/tcs_checker.sv
module tcs_checker (
    input logic clk,
    input logic rst_n,
    input logic sel1_n,
    input logic sel2,
    input logic plain_mode,
    input logic rd_en_n,
    input logic tag_wr_n,
    input logic flags_wr_n,
    input logic ack_force_hi,
    input logic ack_hold,
    input logic tag_rd_oe,
    input logic hit,
    input logic hit_oe,
    input logic ack_n
);

    logic sel_c;
    logic cmp_c;

    assign sel_c = !sel1_n && sel2;
    assign cmp_c = sel_c && rd_en_n && tag_wr_n && flags_wr_n;

    p_desel_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_c |=> (!hit_oe && !tag_rd_oe && ack_n));

    p_read_nohit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tag_rd_oe |-> !hit);

    p_write_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_c && !tag_wr_n) |=> (!tag_rd_oe && !hit));

    p_force_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_c && ack_force_hi) |=> ack_n);

    p_hold_plain_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_c && plain_mode && ack_hold && !ack_force_hi) |=> (hit == !ack_n));

    p_noncmp_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_c |=> ack_n);

    p_reset_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!hit_oe && !tag_rd_oe && ack_n));

endmodule

bind tag_cache_store tcs_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sel1_n       (sel1_n),
    .sel2         (sel2),
    .plain_mode   (plain_mode),
    .rd_en_n      (rd_en_n),
    .tag_wr_n     (tag_wr_n),
    .flags_wr_n   (flags_wr_n),
    .ack_force_hi (ack_force_hi),
    .ack_hold     (ack_hold),
    .tag_rd_oe    (tag_rd_oe),
    .hit          (hit),
    .hit_oe       (hit_oe),
    .ack_n        (ack_n)
);

// File: tb/tag_cache_store_tb_top.sv
`timescale 1ns/1ps
module tag_cache_store_tb_top;

    localparam int IDX_W = 10;
    localparam int TAG_W = 12;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             sel1_n, sel2, plain_mode;
    logic [IDX_W-1:0] index;
    logic             rd_en_n, tag_wr_n, flags_wr_n;
    logic [TAG_W-1:0] tag_in;
    logic             flag_valid_in, flag_dirty_in, flag_wt_in;
    logic [TAG_W-1:0] tag_rd;
    logic [2:0]       flags_rd;
    logic             tag_rd_oe, hit, hit_oe;
    logic             ack_force_hi, ack_hold, ext_ack_n, ack_oe_n;
    logic             ack_n, ack_oe;

    int n_checks = 0;
    int n_errors = 0;

    always #2.5 clk = ~clk;

    tag_cache_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .sel1_n(sel1_n), .sel2(sel2),
        .plain_mode(plain_mode), .index(index), .rd_en_n(rd_en_n),
        .tag_wr_n(tag_wr_n), .flags_wr_n(flags_wr_n), .tag_in(tag_in),
        .flag_valid_in(flag_valid_in), .flag_dirty_in(flag_dirty_in),
        .flag_wt_in(flag_wt_in), .tag_rd(tag_rd), .flags_rd(flags_rd),
        .tag_rd_oe(tag_rd_oe), .hit(hit), .hit_oe(hit_oe),
        .ack_force_hi(ack_force_hi), .ack_hold(ack_hold),
        .ext_ack_n(ext_ack_n), .ack_oe_n(ack_oe_n), .ack_n(ack_n),
        .ack_oe(ack_oe)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_inputs();
        sel1_n = 1'b0; sel2 = 1'b1; plain_mode = 1'b0; index = '0;
        rd_en_n = 1'b1; tag_wr_n = 1'b1; flags_wr_n = 1'b1; tag_in = '0;
        flag_valid_in = 1'b0; flag_dirty_in = 1'b0; flag_wt_in = 1'b0;
        ack_force_hi = 1'b0; ack_hold = 1'b0; ext_ack_n = 1'b1; ack_oe_n = 1'b0;
    endtask

    task automatic wr_tag(input int a, input logic [TAG_W-1:0] t);
        idle_inputs(); index = a[IDX_W-1:0]; tag_in = t; tag_wr_n = 1'b0;
        step();
        check("R3", "tag_rd_oe after tag write", tag_rd_oe, 0);
        check("R3", "hit after tag write", hit, 0);
    endtask

    task automatic wr_flags(input int a, input logic v, input logic d, input logic w);
        idle_inputs(); index = a[IDX_W-1:0]; flags_wr_n = 1'b0;
        flag_valid_in = v; flag_dirty_in = d; flag_wt_in = w;
        step();
    endtask

    task automatic rd_expect(input string req, input int a,
                             input logic [TAG_W-1:0] et, input logic [2:0] ef);
        idle_inputs(); index = a[IDX_W-1:0]; rd_en_n = 1'b0;
        step();
        check(req, "tag_rd_oe on read", tag_rd_oe, 1);
        check(req, "hit on read", hit, 0);
        check(req, "tag_rd", tag_rd, et);
        check(req, "flags_rd", flags_rd, ef);
    endtask

    task automatic cmp_expect(input string req, input int a, input logic [TAG_W-1:0] t,
                              input logic pm, input logic frc, input logic hold,
                              input logic ext, input logic eh, input logic eack);
        idle_inputs(); index = a[IDX_W-1:0]; tag_in = t; plain_mode = pm;
        ack_force_hi = frc; ack_hold = hold; ext_ack_n = ext;
        step();
        check(req, "hit_oe on compare", hit_oe, 1);
        check(req, "hit", hit, eh);
        check(req, "ack_n", ack_n, eack);
    endtask

    task automatic t_reset();
        idle_inputs(); rst_n = 1'b0;
        step(); step();
        rst_n = 1'b1;
        check("R13", "hit_oe after reset", hit_oe, 0);
        check("R13", "tag_rd_oe after reset", tag_rd_oe, 0);
        check("R13", "ack_n after reset", ack_n, 1);
    endtask

    task automatic t_deselect();
        idle_inputs(); sel1_n = 1'b1; rd_en_n = 1'b0;
        step();
        check("R1", "hit_oe sel1_n high", hit_oe, 0);
        check("R1", "tag_rd_oe sel1_n high", tag_rd_oe, 0);
        idle_inputs(); sel2 = 1'b0; ext_ack_n = 1'b0; ack_hold = 1'b1;
        step();
        check("R1", "hit_oe sel2 low", hit_oe, 0);
        check("R1", "ack_n sel2 low", ack_n, 1);
    endtask

    task automatic t_write_read();
        wr_tag(5, 12'hABC);
        wr_flags(5, 1'b1, 1'b1, 1'b0);
        rd_expect("R2", 5, 12'hABC, 3'b011);
        // R4: both writes in one edge, then flags rewritten alone
        idle_inputs(); index = 30; tag_in = 12'h3C5; tag_wr_n = 1'b0; flags_wr_n = 1'b0;
        flag_valid_in = 1'b1; flag_dirty_in = 1'b0; flag_wt_in = 1'b1;
        step();
        rd_expect("R4", 30, 12'h3C5, 3'b101);
        wr_flags(30, 1'b0, 1'b1, 1'b0);
        rd_expect("R4", 30, 12'h3C5, 3'b010);
    endtask

    task automatic t_cmp_qualified();
        cmp_expect("R5", 5, 12'hABC, 0, 0, 0, 1, 1, 1);
        cmp_expect("R11", 5, 12'hABC, 0, 0, 0, 0, 1, 0);
        cmp_expect("R10", 5, 12'hABC, 0, 0, 1, 1, 1, 0);
        cmp_expect("R5", 5, 12'hABD, 0, 0, 1, 0, 0, 1);
        cmp_expect("R8", 5, 12'hABC, 0, 1, 1, 0, 1, 1);
        wr_tag(9, 12'h123);
        wr_flags(9, 1'b0, 1'b0, 1'b0);
        cmp_expect("R6", 9, 12'h123, 0, 0, 1, 0, 0, 1);
        wr_tag(12, 12'h077);
        wr_flags(12, 1'b1, 1'b0, 1'b1);
        cmp_expect("R9", 12, 12'h077, 0, 0, 1, 0, 1, 1);
    endtask

    task automatic t_cmp_plain();
        cmp_expect("R7", 9, 12'h123, 1, 0, 1, 1, 1, 0);
        cmp_expect("R7", 12, 12'h077, 1, 0, 1, 1, 1, 0);
        cmp_expect("R7", 9, 12'h124, 1, 0, 1, 0, 0, 1);
        cmp_expect("R11", 9, 12'h123, 1, 0, 0, 1, 1, 1);
    endtask

    task automatic t_back_to_back();
        wr_tag(20, 12'h555);
        cmp_expect("R14", 20, 12'h555, 1, 0, 0, 0, 1, 0);
        cmp_expect("R14", 20, 12'h555, 0, 0, 0, 0, 0, 1);
        wr_flags(20, 1'b1, 1'b0, 1'b0);
        cmp_expect("R14", 20, 12'h555, 0, 0, 0, 0, 1, 0);
    endtask

    task automatic t_ack_enable();
        idle_inputs(); ack_oe_n = 1'b0; #1;
        check("R12", "ack_oe with enable low", ack_oe, 1);
        ack_oe_n = 1'b1; #1;
        check("R12", "ack_oe with enable high", ack_oe, 0);
        step();
    endtask

    task automatic t_reset_clears();
        idle_inputs(); rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        check("R13", "hit_oe after second reset", hit_oe, 0);
        idle_inputs(); index = 5; rd_en_n = 1'b0;
        step();
        check("R13", "valid flag cleared by reset", flags_rd[0], 0);
        cmp_expect("R13", 5, 12'hABC, 0, 0, 1, 0, 0, 1);
    endtask

    initial begin
        #(5.0 * 100000);
        n_errors++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        idle_inputs();
        rst_n = 1'b0;
        #1;
        t_reset();
        t_deselect();
        t_write_read();
        t_cmp_qualified();
        t_cmp_plain();
        t_back_to_back();
        t_ack_enable();
        t_reset_clears();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule